// File: doc/BRIEF.md
# DMA Word Arbiter

This block decides, one word at a time, which of several DMA channels owns the single shared DMA address and data path. It also settles contention between that path and a processor core, both for the external bus and for the banks (partitions) of internal memory. Each word is modelled as a read phase followed by a write phase, and each phase takes one or more cycles. Wait states from the external bus, presented on `stall`, freeze whichever phase is in progress.

Channels present a request when they are both enabled and triggered. Each request carries a 2-bit priority and a continuous-mode flag. The arbiter picks a winner only when the path is idle or a word is ending. The highest priority level always wins. Inside one level, channels take turns one word each, unless the channel that just moved a word is in continuous mode and is still requesting. For each phase the core presents one request with a resource code. The arbiter grants it unless the DMA word holds that resource, or wins it under the selected core/DMA policy.

Top module: `dma_word_arb`

## Requirements
- R1: While `rst_n` is low, `ch_gnt` is all zero, `active` is 0 and `act_ch` is 0. After reset, every level's turn pointer is at channel 0.
- R2: At a word boundary the winner is a requesting channel with the highest priority code among all requesters (00 lowest, 11 highest).
- R3: Among requesters at the winning level, the grant goes to the first requester at or after that level's turn pointer, searching upward and wrapping. The pointer then moves to the channel after the one granted. Each grant lasts one word.
- R4: A channel whose continuous bit is 1 keeps the path at the next boundary if it is still requesting and no higher level is requesting.
- R5: A higher-priority request that arrives mid-word takes over only after the current word ends. When it leaves, its level's round-robin order resumes from that level's pointer.
- R6: A word is at least one read cycle followed by at least one write cycle. `ch_gnt` is one-hot and constant for the whole word. A new word may start in the cycle right after a write ends.
- R7: While `stall` is 1, the current phase does not end and the owning channel does not change.
- R8: Resource code 0 means the external bus. When the core and a read that has not yet started both want it, the DMA read wins only if DMA ranks higher. With `core_mode` = 01, DMA ranks higher. With 10 the two rank equal and the core goes first. With 11 the core ranks higher. With 00, the owning channel's priority is compared with `core_prio`.
- R9: Resource codes 1 to 3 are internal partitions. If the core requests the partition that a not-yet-started read needs, the core is granted and the read waits. The read also waits while the core was granted that partition in the previous cycle.
- R10: The core is denied any resource held by a started DMA phase. The write phase holds its write resource. During the write, the core is granted any other resource.
- R11: `active` is 1 exactly while a channel owns the path, and `act_ch` gives that channel's index (0 to 5). Otherwise `act_ch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, deasserted in step with clk |
| ch_req | input | NUM_CH | Per channel: enabled and triggered |
| ch_prio | input | NUM_CH*PRIO_W | Per-channel priority, channel i at [i*PRIO_W +: PRIO_W] |
| ch_cont | input | NUM_CH | Per-channel continuous-mode flag |
| ch_rd_res | input | NUM_CH*RES_W | Per-channel read resource code (0 external) |
| ch_wr_res | input | NUM_CH*RES_W | Per-channel write resource code (0 external) |
| core_req | input | 1 | Core wants a resource this cycle |
| core_res | input | RES_W | Resource the core wants |
| core_prio | input | PRIO_W | Core priority for the compare policy |
| core_mode | input | 2 | Core/DMA policy for the external bus |
| stall | input | 1 | Wait state on the owning channel's access |
| ch_gnt | output | NUM_CH | One-hot owner of the DMA path |
| core_gnt | output | 1 | Core access allowed this cycle |
| act_ch | output | IDX_W | Index of the owning channel |
| active | output | 1 | A channel owns the path |

## Verification
The bench builds the block at its defaults: six channels, 2-bit priorities and 2-bit resource codes. Six channels make the turn pointer wrap from 5 to 0 at a width that is not a power of two. All four priority levels and all four policy codes are driven, and the resource codes give the external bus plus three partitions. With these values, preemption at a word edge, continuous hold, one-cycle partition idle gaps and stalled reads can each be seen at the ports with a few requests.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RD   = 2'b01,
    PH_WR   = 2'b10
  } phase_e;

  localparam logic [1:0] CM_DYN     = 2'b00;
  localparam logic [1:0] CM_DMA_HI  = 2'b01;
  localparam logic [1:0] CM_EQ      = 2'b10;
  localparam logic [1:0] CM_CORE_HI = 2'b11;

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 6,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 3,
  parameter int LEVELS = 4
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  input  logic [NUM_CH-1:0]        cont,
  input  logic                     hold_vld,
  input  logic [IDX_W-1:0]         hold_idx,
  input  logic [LEVELS*IDX_W-1:0]  ptr_flat,
  output logic                     win_vld,
  output logic [IDX_W-1:0]         win_idx,
  output logic [PRIO_W-1:0]        win_lvl
);

  logic [PRIO_W-1:0] prio_a [NUM_CH];
  logic [IDX_W-1:0]  ptr_a  [LEVELS];
  logic [NUM_CH-1:0] cand;
  logic [PRIO_W-1:0] top_lvl;
  logic [IDX_W-1:0]  cur_ptr;
  logic [IDX_W-1:0]  rr_idx;
  logic              rr_hit;
  logic              keep;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
      assign cand[g]   = req[g] && (prio_a[g] == top_lvl);
    end
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign ptr_a[g] = ptr_flat[g*IDX_W +: IDX_W];
    end
  endgenerate

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input int k);
    int s;
    s = int'(a) + k;
    if (s >= NUM_CH) s = s - NUM_CH;
    return IDX_W'(s);
  endfunction

  // highest requested level
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (prio_a[i] > top_lvl)) top_lvl = prio_a[i];
    end
  end

  assign cur_ptr = ptr_a[top_lvl];

  // first candidate at or after the level pointer
  always_comb begin
    rr_idx = '0;
    rr_hit = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!rr_hit && cand[wrap_add(cur_ptr, k)]) begin
        rr_hit = 1'b1;
        rr_idx = wrap_add(cur_ptr, k);
      end
    end
  end

  assign keep    = hold_vld && cand[hold_idx] && cont[hold_idx];
  assign win_vld = |req;
  assign win_idx = keep ? hold_idx : rr_idx;
  assign win_lvl = top_lvl;

endmodule

// File: rtl/dma_arb_core_gate.sv
module dma_arb_core_gate
  import dma_arb_pkg::*;
#(
  parameter int RES_W  = 2,
  parameter int PRIO_W = 2
) (
  input  logic              in_rd,
  input  logic              in_wr,
  input  logic              rd_on,
  input  logic [RES_W-1:0]  rd_res,
  input  logic [RES_W-1:0]  wr_res,
  input  logic [PRIO_W-1:0] dma_prio,
  input  logic              core_req,
  input  logic [RES_W-1:0]  core_res,
  input  logic [PRIO_W-1:0] core_prio,
  input  logic [1:0]        core_mode,
  input  logic              prev_vld,
  input  logic [RES_W-1:0]  prev_res,
  output logic              rd_blk,
  output logic              core_gnt
);

  logic dma_first;
  logic same_rd;
  logic rd_internal;
  logic prev_hit;

  always_comb begin
    case (core_mode)
      CM_DMA_HI:        dma_first = 1'b1;
      CM_EQ, CM_CORE_HI: dma_first = 1'b0;
      default:          dma_first = (dma_prio > core_prio);
    endcase
  end

  assign same_rd     = core_req && (core_res == rd_res);
  assign rd_internal = (rd_res != '0);
  assign prev_hit    = prev_vld && (prev_res == rd_res) && rd_internal;

  always_comb begin
    rd_blk   = 1'b0;
    core_gnt = core_req;
    if (in_rd && !rd_on) begin
      rd_blk   = (same_rd && (rd_internal || !dma_first)) || prev_hit;
      core_gnt = core_req && !(same_rd && !rd_blk);
    end else if (in_rd) begin
      core_gnt = core_req && !same_rd;
    end else if (in_wr) begin
      core_gnt = core_req && (core_res != wr_res);
    end
  end

endmodule

// File: rtl/dma_word_arb.sv
module dma_word_arb
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int PRIO_W = 2,
  parameter int RES_W  = 2,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int LEVELS = 1 << PRIO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic [NUM_CH-1:0]        ch_cont,
  input  logic [NUM_CH*RES_W-1:0]  ch_rd_res,
  input  logic [NUM_CH*RES_W-1:0]  ch_wr_res,
  input  logic                     core_req,
  input  logic [RES_W-1:0]         core_res,
  input  logic [PRIO_W-1:0]        core_prio,
  input  logic [1:0]               core_mode,
  input  logic                     stall,
  output logic [NUM_CH-1:0]        ch_gnt,
  output logic                     core_gnt,
  output logic [IDX_W-1:0]         act_ch,
  output logic                     active
);

  phase_e            phase_q, phase_d;
  logic [IDX_W-1:0]  cur_q, cur_d;
  logic              rd_on_q, rd_on_d;
  logic [IDX_W-1:0]  rr_ptr_q [LEVELS];
  logic              prev_vld_q;
  logic [RES_W-1:0]  prev_res_q;
  logic              past_ok_q;

  logic [PRIO_W-1:0] prio_a   [NUM_CH];
  logic [RES_W-1:0]  rd_res_a [NUM_CH];
  logic [RES_W-1:0]  wr_res_a [NUM_CH];
  logic [LEVELS*IDX_W-1:0] ptr_flat;

  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_lvl;
  logic [IDX_W-1:0]  nxt_ptr;
  logic              ptr_en;
  logic              sel_en;
  logic              rd_done;
  logic              rd_blk;
  logic              busy;
  logic [RES_W-1:0]  rd_res_cur;
  logic [RES_W-1:0]  wr_res_cur;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_unpack
      assign prio_a[g]   = ch_prio[g*PRIO_W +: PRIO_W];
      assign rd_res_a[g] = ch_rd_res[g*RES_W +: RES_W];
      assign wr_res_a[g] = ch_wr_res[g*RES_W +: RES_W];
      assign ch_gnt[g]   = busy && (cur_q == IDX_W'(g));
    end
    for (g = 0; g < LEVELS; g++) begin : g_ptr
      assign ptr_flat[g*IDX_W +: IDX_W] = rr_ptr_q[g];
    end
  endgenerate

  assign busy       = (phase_q != PH_IDLE);
  assign active     = busy;
  assign act_ch     = busy ? cur_q : '0;
  assign rd_res_cur = rd_res_a[cur_q];
  assign wr_res_cur = wr_res_a[cur_q];

  dma_arb_pick #(
    .NUM_CH (NUM_CH),
    .PRIO_W (PRIO_W),
    .IDX_W  (IDX_W),
    .LEVELS (LEVELS)
  ) u_pick (
    .req       (ch_req),
    .prio_flat (ch_prio),
    .cont      (ch_cont),
    .hold_vld  (phase_q == PH_WR),
    .hold_idx  (cur_q),
    .ptr_flat  (ptr_flat),
    .win_vld   (win_vld),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  dma_arb_core_gate #(
    .RES_W  (RES_W),
    .PRIO_W (PRIO_W)
  ) u_gate (
    .in_rd     (phase_q == PH_RD),
    .in_wr     (phase_q == PH_WR),
    .rd_on     (rd_on_q),
    .rd_res    (rd_res_cur),
    .wr_res    (wr_res_cur),
    .dma_prio  (prio_a[cur_q]),
    .core_req  (core_req),
    .core_res  (core_res),
    .core_prio (core_prio),
    .core_mode (core_mode),
    .prev_vld  (prev_vld_q),
    .prev_res  (prev_res_q),
    .rd_blk    (rd_blk),
    .core_gnt  (core_gnt)
  );

  assign sel_en  = (phase_q == PH_IDLE) || ((phase_q == PH_WR) && !stall);
  assign rd_done = (phase_q == PH_RD) && !rd_blk && !stall;
  assign nxt_ptr = (win_idx == IDX_W'(NUM_CH-1)) ? '0 : win_idx + 1'b1;

  // next-state
  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    rd_on_d = 1'b0;
    ptr_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (win_vld) begin
          phase_d = PH_RD;
          cur_d   = win_idx;
          ptr_en  = 1'b1;
        end
      end
      PH_RD: begin
        if (rd_done) phase_d = PH_WR;
        else         rd_on_d = rd_on_q || !rd_blk;
      end
      PH_WR: begin
        if (!stall) begin
          if (win_vld) begin
            phase_d = PH_RD;
            cur_d   = win_idx;
            ptr_en  = 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cur_q      <= '0;
      rd_on_q    <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_res_q <= '0;
      past_ok_q  <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cur_q      <= cur_d;
      rd_on_q    <= rd_on_d;
      prev_vld_q <= core_gnt && (core_res != '0);
      prev_res_q <= core_res;
      past_ok_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LEVELS; l++) rr_ptr_q[l] <= '0;
    end else if (ptr_en) begin
      rr_ptr_q[win_lvl] <= nxt_ptr;
    end
  end

  // assertions
  AST_WORD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (phase_q == PH_WR) && $stable(cur_q)); // R6

  AST_GNT_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD) |=> $stable(ch_gnt) && active); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (phase_q == PH_WR)) |=> (phase_q == PH_WR) && $stable(ch_gnt)); // R7

  AST_CORE_OFF_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (core_gnt && (phase_q == PH_WR)) |-> (core_res != wr_res_cur)); // R10

  AST_PART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && rd_done && (rd_res_cur != '0)) |->
      !($past(core_gnt) && ($past(core_res) == rd_res_cur))); // R9

  AST_EXT_DMA_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RD) && !rd_on_q && core_req && (core_res == '0) &&
     (rd_res_cur == '0) && (core_mode == CM_DMA_HI)) |-> !core_gnt); // R8

  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ast
      AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_en && win_vld && ch_req[g]) |-> (prio_a[g] <= prio_a[win_idx])); // R2
    end
  endgenerate

endmodule

// File: tb/sim_dma_word_arb.sv
`timescale 1ns/1ps
module sim_dma_word_arb;

  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    ch_req;
  logic [11:0]   ch_prio;
  logic [5:0]    ch_cont;
  logic [11:0]   ch_rd_res;
  logic [11:0]   ch_wr_res;
  logic          core_req;
  logic [1:0]    core_res;
  logic [1:0]    core_prio;
  logic [1:0]    core_mode;
  logic          stall;
  logic [5:0]    ch_gnt;
  logic          core_gnt;
  logic [2:0]    act_ch;
  logic          active;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_word_arb u0 (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_prio(ch_prio), .ch_cont(ch_cont),
    .ch_rd_res(ch_rd_res), .ch_wr_res(ch_wr_res), .core_req(core_req), .core_res(core_res),
    .core_prio(core_prio), .core_mode(core_mode), .stall(stall), .ch_gnt(ch_gnt),
    .core_gnt(core_gnt), .act_ch(act_ch), .active(active)
  );

  // {req[6], prio[12], cont[6], word0..word3 channel}
  localparam logic [35:0] VEC [5] = '{
    {6'b011010, 12'b00_00_00_00_00_00, 6'b000000, 3'd1, 3'd3, 3'd4, 3'd1},
    {6'b100101, 12'b01_00_00_11_00_01, 6'b000000, 3'd2, 3'd2, 3'd2, 3'd2},
    {6'b000111, 12'b00_00_00_10_10_10, 6'b000010, 3'd0, 3'd1, 3'd1, 3'd1},
    {6'b111111, 12'b00_00_01_00_00_01, 6'b000000, 3'd0, 3'd3, 3'd0, 3'd3},
    {6'b010100, 12'b00_11_00_11_00_00, 6'b010000, 3'd2, 3'd4, 3'd4, 3'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [5:0] req, input logic [11:0] prio, input logic [5:0] cont,
                       input logic [11:0] rd, input logic [11:0] wr, input logic creq,
                       input logic [1:0] cres, input logic [1:0] cprio, input logic [1:0] cmode);
    @(negedge clk);
    rst_n = 1'b0;
    ch_req = req; ch_prio = prio; ch_cont = cont; ch_rd_res = rd; ch_wr_res = wr;
    core_req = creq; core_res = cres; core_prio = cprio; core_mode = cmode; stall = 1'b0;
    @(negedge clk);
    chk("R1 gnt in reset", int'(ch_gnt), 0);
    chk("R1 active in reset", int'(active), 0);
    chk("R1 act_ch in reset", int'(act_ch), 0);
    rst_n = 1'b1;
  endtask

  task automatic ext_case(input logic [1:0] mode, input logic [1:0] cprio, input logic exp_core);
    start(6'b000010, 12'b00_00_00_00_10_00, 6'b0, 12'b0, 12'b01_01_01_01_01_01,
          1'b1, 2'd0, cprio, mode);
    @(negedge clk);
    chk("R8 owner", int'(ch_gnt), 2);
    chk($sformatf("R8 core_gnt mode=%0d cprio=%0d", mode, cprio), int'(core_gnt), int'(exp_core));
    @(negedge clk);
    chk("R10 core on other resource", int'(core_gnt), 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ch_req = '0; ch_prio = '0; ch_cont = '0; ch_rd_res = '0; ch_wr_res = '0;
    core_req = 1'b0; core_res = '0; core_prio = '0; core_mode = '0; stall = 1'b0;

    // table: R2 R3 R4 R6 R11
    for (int v = 0; v < 5; v++) begin
      start(VEC[v][35:30], VEC[v][29:18], VEC[v][17:12], 12'b01_01_01_01_01_01,
            12'b10_10_10_10_10_10, 1'b0, 2'd0, 2'd0, 2'd0);
      for (int w = 0; w < 4; w++) begin
        int exp_ch;
        exp_ch = int'(VEC[v][11 - 3*w -: 3]);
        @(negedge clk);
        chk($sformatf("R2/R3/R4 vec%0d word%0d read", v, w), int'(ch_gnt), 1 << exp_ch);
        chk("R11 act_ch", int'(act_ch), exp_ch);
        chk("R11 active", int'(active), 1);
        @(negedge clk);
        chk($sformatf("R6 vec%0d word%0d write", v, w), int'(ch_gnt), 1 << exp_ch);
      end
    end

    // R5: preempt only at word end, lower group resumes
    start(6'b000011, 12'b0, 6'b0, 12'b01_01_01_01_01_01, 12'b10_10_10_10_10_10,
          1'b0, 2'd0, 2'd0, 2'd0);
    @(negedge clk);
    chk("R5 first word", int'(ch_gnt), 1);
    ch_req = 6'b001011; ch_prio = 12'b00_00_10_00_00_00;
    @(negedge clk);
    chk("R5 no mid-word preempt", int'(ch_gnt), 1);
    @(negedge clk);
    chk("R5 preempt at boundary", int'(ch_gnt), 8);
    @(negedge clk);
    ch_req = 6'b000011;
    @(negedge clk);
    chk("R5 round robin resumes", int'(ch_gnt), 2);

    // R7: stall freezes the read
    start(6'b000100, 12'b0, 6'b0, 12'b0, 12'b0, 1'b0, 2'd0, 2'd0, 2'd0);
    @(negedge clk);
    stall = 1'b1; ch_req = 6'b010100; ch_prio = 12'b00_11_00_00_00_00;
    @(negedge clk);
    @(negedge clk);
    chk("R7 owner held", int'(ch_gnt), 4);
    chk("R7 act_ch held", int'(act_ch), 2);
    @(negedge clk);
    stall = 1'b0;
    @(negedge clk);
    chk("R7 write after stall", int'(ch_gnt), 4);
    @(negedge clk);
    chk("R7 next word", int'(ch_gnt), 16);

    // R8: external bus policy
    ext_case(2'b01, 2'd3, 1'b0);
    ext_case(2'b10, 2'd0, 1'b1);
    ext_case(2'b11, 2'd0, 1'b1);
    ext_case(2'b00, 2'd1, 1'b0);
    ext_case(2'b00, 2'd2, 1'b1);
    ext_case(2'b00, 2'd3, 1'b1);

    // R9/R10: internal partition, idle gap, write holds
    start(6'b000010, 12'b0, 6'b0, 12'b01_01_01_01_01_01, 12'b10_10_10_10_10_10,
          1'b1, 2'd1, 2'd0, 2'd0);
    @(negedge clk);
    chk("R9 core wins partition", int'(core_gnt), 1);
    core_res = 2'd2;
    @(negedge clk);
    chk("R9 read waits idle cycle", int'(core_gnt), 1);
    @(negedge clk);
    chk("R10 write holds partition", int'(core_gnt), 0);
    chk("R10 owner", int'(ch_gnt), 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule